// File: doc/BRIEF.md
# Cache event performance monitor

A small register-mapped monitor that counts activity in a shared cache controller. Two identical 32-bit counters each choose one event line from a bundle of single-cycle pulses driven by the cache. A global enable bit gates every increment. Software reads and rewrites the counter values, so a periodic poller can sample a counter and then reset it before it fills.

Counters do not wrap. On reaching all-ones a counter stops and further events are lost. Each counter has an interrupt mode that raises a shared level interrupt either when the counter fills or on any increment. The interrupt stays raised until software rewrites that counter's value. A parameter selects a base event set of nine sources or an extended set of fifteen.

The register port is a simple single-cycle write strobe with a combinational read of the addressed register.

Top module: `cache_evt_pmu`

## Requirements
- R1: After reset every mapped register reads zero and `irq_o` is low.
- R2: Byte addresses are: control 0x00, counter 1 configuration 0x04, counter 0 configuration 0x08, counter 1 value 0x0C, counter 0 value 0x10. Control bit 0 is the global enable. A configuration register holds the source code in bits [5:2] and the interrupt mode in bits [1:0]. Unused bits and unmapped addresses read zero.
- R3: A counter at 0xFFFFFFFF keeps that value on further matching events.
- R4: While the global enable is clear, no counter increments.
- R5: Source code 0 disables a counter; it counts nothing.
- R6: A counter with source code k (k ≥ 1) increments by one for each cycle in which `evt_i[k-1]` is high, and ignores every other event bit.
- R7: With `EXT_EVENTS` = 0 only codes 1 to 9 count; codes 10 to 15 count nothing. With `EXT_EVENTS` = 1, codes 1 to 15 all count.
- R8: A write to a value register loads the written data on the next edge. If a matching event arrives in the same cycle, the written value wins.
- R9: When both counters select the same source, both increment on each matching pulse.
- R10: Interrupt mode 1 sets a counter's pending flag when an increment brings it to 0xFFFFFFFF. A write of the value register clears the flag. Loading 0xFFFFFFFF by a write does not set it.
- R11: Interrupt mode 2 sets the pending flag on every increment. Modes 0 and 3 never set it. `irq_o` is high exactly when either counter's flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when high together with reg_req_i |
| reg_addr_i | input | 5 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register, combinational |
| evt_i | input | 15 | Event pulses; bit k-1 carries source code k |
| irq_o | output | 1 | Level interrupt, OR of both pending flags |

## Verification
A stuck or misdecoded source selection shows up at the value registers one cycle after the first event pulse. A missing saturation guard shows as a value of zero right after the count passes all-ones. A wrong pending flag shows on `irq_o` in the cycle after the increment that should set it, or after the value write that should clear it. The bench reads both counter values and the interrupt after every stimulated cycle, so any divergence appears within one clock. The bench drives a base-set and an extended-set instance with the same stimulus, which exposes any mistake in the supported-code boundary.

// File: rtl/cevt_pkg.sv
package cevt_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int NUM_CNT  = 2;
  localparam int MAX_SRC  = 15;
  localparam int BASE_SRC = 9;
  localparam int SRC_W    = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_CFG0 = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_VAL0 = 5'h10;

  typedef enum logic [1:0] {
    IRQ_OFF    = 2'b00,
    IRQ_AT_MAX = 2'b01,
    IRQ_EACH   = 2'b10,
    IRQ_RSVD   = 2'b11
  } irq_mode_e;

  // src in [5:2], irq mode in [1:0]
  typedef struct packed {
    logic [SRC_W-1:0] src;
    irq_mode_e        irq;
  } cnt_cfg_t;

  localparam int CFG_W = $bits(cnt_cfg_t);

  // counter pairs placed in descending order: higher index at lower address
  function automatic logic [ADDR_W-1:0] cfg_addr(int idx);
    return ADDR_CFG0 - ADDR_W'(4 * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] val_addr(int idx);
    return ADDR_VAL0 - ADDR_W'(4 * idx);
  endfunction
endpackage

// File: rtl/cevt_select.sv
module cevt_select
  import cevt_pkg::*;
#(
  parameter bit EXT_EVENTS = 1'b1
) (
  input  logic [SRC_W-1:0]   src_i,
  input  logic [MAX_SRC-1:0] evt_i,
  output logic               hit_o
);
  localparam int TOP_SRC = EXT_EVENTS ? MAX_SRC : BASE_SRC;

  logic [MAX_SRC:0] evt_by_code;
  logic [MAX_SRC:0] supported;

  assign evt_by_code = {evt_i, 1'b0};

  for (genvar k = 0; k <= MAX_SRC; k++) begin : g_supp
    if (k >= 1 && k <= TOP_SRC) begin : g_on
      assign supported[k] = 1'b1;
    end else begin : g_off
      assign supported[k] = 1'b0;
    end
  end

  assign hit_o = supported[src_i] & evt_by_code[src_i];
endmodule

// File: rtl/cevt_counter.sv
module cevt_counter
  import cevt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_req_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  irq_mode_e        irq_mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  localparam logic [CNT_W-1:0] FULL     = '1;
  localparam logic [CNT_W-1:0] NEAR_MAX = FULL - CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             inc;
  logic             pend_set;

  assign inc      = inc_req_i & (cnt_q != FULL) & ~wr_i;
  assign pend_set = inc & ((irq_mode_i == IRQ_EACH) |
                           ((irq_mode_i == IRQ_AT_MAX) & (cnt_q == NEAR_MAX)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q  <= wdata_i;
      pend_q <= 1'b0;
    end else begin
      if (inc)      cnt_q  <= cnt_q + CNT_W'(1);
      if (pend_set) pend_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cache_evt_pmu.sv
module cache_evt_pmu
  import cevt_pkg::*;
#(
  parameter bit EXT_EVENTS = 1'b1,
  parameter int CNT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [MAX_SRC-1:0] evt_i,
  output logic              irq_o
);
  logic                            wr;
  logic                            glob_en_q;
  cnt_cfg_t                        cfg_q [NUM_CNT];
  logic [NUM_CNT-1:0]              hit;
  logic [NUM_CNT-1:0]              val_wr;
  logic [NUM_CNT-1:0]              pend;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_val;

  assign wr = reg_req_i & reg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            glob_en_q <= 1'b0;
    else if (wr && reg_addr_i == ADDR_CTRL) glob_en_q <= reg_wdata_i[0];
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] CFG_A = cfg_addr(i);
    localparam logic [ADDR_W-1:0] VAL_A = val_addr(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        cfg_q[i] <= '0;
      else if (wr && reg_addr_i == CFG_A) cfg_q[i] <= cnt_cfg_t'(reg_wdata_i[CFG_W-1:0]);
    end

    assign val_wr[i] = wr & (reg_addr_i == VAL_A);

    cevt_select #(
      .EXT_EVENTS(EXT_EVENTS)
    ) u_sel (
      .src_i(cfg_q[i].src),
      .evt_i(evt_i),
      .hit_o(hit[i])
    );

    cevt_counter #(
      .CNT_W(CNT_W)
    ) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_req_i (glob_en_q & hit[i]),
      .wr_i      (val_wr[i]),
      .wdata_i   (reg_wdata_i[CNT_W-1:0]),
      .irq_mode_i(cfg_q[i].irq),
      .cnt_o     (cnt_val[i]),
      .pend_o    (pend[i])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CTRL) reg_rdata_o[0] = glob_en_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr_i == cfg_addr(i)) reg_rdata_o[CFG_W-1:0] = cfg_q[i];
      if (reg_addr_i == val_addr(i)) reg_rdata_o[CNT_W-1:0] = cnt_val[i];
    end
  end

  assign irq_o = |pend;
endmodule

// File: rtl/cache_evt_pmu_chk.sv
module cache_evt_pmu_chk
  import cevt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          en_i,
  input logic [NUM_CNT-1:0]            val_wr_i,
  input logic [CNT_W-1:0]              wdata_i,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_CNT-1:0]            pend_i
);
  localparam logic [CNT_W-1:0] FULL = '1;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    assert_hold_at_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i[i] == FULL && !val_wr_i[i]) |=> cnt_i[i] == FULL);

    assert_no_count_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !val_wr_i[i]) |=> cnt_i[i] == $past(cnt_i[i]));

    assert_single_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !val_wr_i[i] |=> (cnt_i[i] == $past(cnt_i[i]) || cnt_i[i] == $past(cnt_i[i]) + CNT_W'(1)));

    assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      val_wr_i[i] |=> cnt_i[i] == $past(wdata_i));

    assert_pend_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[i] && !val_wr_i[i]) |=> pend_i[i]);

    assert_pend_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      val_wr_i[i] |=> !pend_i[i]);
  end
endmodule

bind cache_evt_pmu cache_evt_pmu_chk #(
  .CNT_W(CNT_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (glob_en_q),
  .val_wr_i(val_wr),
  .wdata_i (reg_wdata_i[CNT_W-1:0]),
  .cnt_i   (cnt_val),
  .pend_i  (pend)
);

// File: tb/cache_evt_pmu_tb_top.sv
module cache_evt_pmu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [14:0] evt = '0;
  logic [31:0] rd [2];
  logic        irq [2];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  // model state per variant: 0 = extended set, 1 = base set
  logic [31:0] m_cnt  [2][2];
  logic        m_pend [2][2];
  logic [5:0]  m_cfg  [2][2];
  logic        m_en   [2];

  always #5 clk = ~clk;

  cache_evt_pmu #(.EXT_EVENTS(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd[0]),
    .evt_i(evt), .irq_o(irq[0]));

  cache_evt_pmu #(.EXT_EVENTS(1'b0)) dut_base_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd[1]),
    .evt_i(evt), .irq_o(irq[1]));

  function automatic logic [4:0] a_val(int i);
    return (i == 0) ? 5'h10 : 5'h0C;
  endfunction

  function automatic logic [4:0] a_cfg(int i);
    return (i == 0) ? 5'h08 : 5'h04;
  endfunction

  function automatic void model_reset();
    for (int v = 0; v < 2; v++) begin
      m_en[v] = 1'b0;
      for (int i = 0; i < 2; i++) begin
        m_cnt[v][i] = '0; m_pend[v][i] = 1'b0; m_cfg[v][i] = '0;
      end
    end
  endfunction

  function automatic void model_step(int v, logic [14:0] e, logic w, logic [4:0] a, logic [31:0] d);
    int top;
    top = (v == 0) ? 15 : 9;
    for (int i = 0; i < 2; i++) begin
      int src;
      logic [1:0] mode;
      logic hit;
      src  = int'(m_cfg[v][i][5:2]);
      mode = m_cfg[v][i][1:0];
      hit  = m_en[v] && src != 0 && src <= top && e[src-1];
      if (w && a == a_val(i)) begin
        m_cnt[v][i] = d; m_pend[v][i] = 1'b0;
      end else if (hit && m_cnt[v][i] != 32'hFFFF_FFFF) begin
        if (mode == 2'b10 || (mode == 2'b01 && m_cnt[v][i] == 32'hFFFF_FFFE)) m_pend[v][i] = 1'b1;
        m_cnt[v][i] = m_cnt[v][i] + 1;
      end
    end
    if (w && a == 5'h00) m_en[v] = d[0];
    for (int i = 0; i < 2; i++) if (w && a == a_cfg(i)) m_cfg[v][i] = d[5:0];
  endfunction

  function automatic logic [31:0] exp_rd(int v, logic [4:0] a);
    case (a)
      5'h00:   return {31'd0, m_en[v]};
      5'h04:   return {26'd0, m_cfg[v][1]};
      5'h08:   return {26'd0, m_cfg[v][0]};
      5'h0C:   return m_cnt[v][1];
      5'h10:   return m_cnt[v][0];
      default: return '0;
    endcase
  endfunction

  task automatic cyc(logic [14:0] e, logic w, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    evt = e; req = w; we = w; addr = a; wdata = d;
    model_step(0, e, w, a, d);
    model_step(1, e, w, a, d);
    @(negedge clk);
    evt = '0; req = 1'b0; we = 1'b0;
  endtask

  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    cyc('0, 1'b1, a, d);
  endtask

  task automatic chk_reg(logic [4:0] a, string tag);
    addr = a;
    #1;
    for (int v = 0; v < 2; v++) begin
      logic [31:0] e;
      e = exp_rd(v, a);
      n_chk++;
      if (rd[v] !== e) begin
        n_fail++;
        $display("FAIL %s dut%0d addr %h: got %h exp %h", tag, v, a, rd[v], e);
      end
    end
  endtask

  task automatic chk_irq(string tag);
    #1;
    for (int v = 0; v < 2; v++) begin
      logic e;
      e = m_pend[v][0] | m_pend[v][1];
      n_chk++;
      if (irq[v] !== e) begin
        n_fail++;
        $display("FAIL %s dut%0d irq: got %b exp %b", tag, v, irq[v], e);
      end
    end
  endtask

  task automatic chk_vals(string tag);
    chk_reg(5'h10, tag);
    chk_reg(5'h0C, tag);
    chk_irq(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7719));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg(5'h00, "R1"); chk_reg(5'h04, "R1"); chk_reg(5'h08, "R1");
    chk_reg(5'h0C, "R1"); chk_reg(5'h10, "R1"); chk_irq("R1");

    // R2 map, field masks, descending pairs
    wr_reg(5'h04, 32'hFFFF_FFFF); chk_reg(5'h04, "R2");
    wr_reg(5'h08, 32'h0000_0014); chk_reg(5'h08, "R2"); chk_reg(5'h04, "R2");
    wr_reg(5'h0C, 32'h1234_5678); chk_reg(5'h0C, "R2"); chk_reg(5'h10, "R2");
    wr_reg(5'h10, 32'h0000_00AB); chk_reg(5'h10, "R2");
    wr_reg(5'h00, 32'hFFFF_FFFE); chk_reg(5'h00, "R2");
    chk_reg(5'h14, "R2"); chk_reg(5'h1C, "R2");
    wr_reg(5'h04, 32'h0); wr_reg(5'h0C, 32'h0); wr_reg(5'h10, 32'h0);

    // R4 disabled globally: counter 0 on code 2
    wr_reg(5'h08, {26'd0, 4'd2, 2'b00});
    cyc(15'h0002, 1'b0, 5'h00, 0); cyc(15'h7FFF, 1'b0, 5'h00, 0);
    chk_vals("R4");

    // R6 counting on code 2 only
    wr_reg(5'h00, 32'h1);
    repeat (3) cyc(15'h0002, 1'b0, 5'h00, 0);
    cyc(15'h7FFD, 1'b0, 5'h00, 0);
    chk_vals("R6");

    // R5 source zero
    wr_reg(5'h08, 32'h0);
    cyc(15'h7FFF, 1'b0, 5'h00, 0); cyc(15'h7FFF, 1'b0, 5'h00, 0);
    chk_vals("R5");

    // R9 shared source code 5
    wr_reg(5'h08, {26'd0, 4'd5, 2'b00}); wr_reg(5'h04, {26'd0, 4'd5, 2'b00});
    cyc(15'h0010, 1'b0, 5'h00, 0); cyc(15'h0010, 1'b0, 5'h00, 0);
    chk_vals("R9");

    // R3 saturation
    wr_reg(5'h10, 32'hFFFF_FFFD);
    repeat (5) cyc(15'h0010, 1'b0, 5'h00, 0);
    chk_vals("R3");

    // R8 write beats simultaneous event
    cyc(15'h0010, 1'b1, 5'h10, 32'h0000_0055);
    chk_vals("R8");
    cyc(15'h0010, 1'b1, 5'h0C, 32'h0000_0100);
    chk_vals("R8");

    // R10 interrupt at saturation, cleared by value write
    wr_reg(5'h08, {26'd0, 4'd5, 2'b01});
    wr_reg(5'h10, 32'hFFFF_FFFF);
    chk_irq("R10");
    wr_reg(5'h10, 32'hFFFF_FFFE);
    chk_irq("R10");
    cyc(15'h0010, 1'b0, 5'h00, 0); chk_vals("R10");
    cyc(15'h0010, 1'b0, 5'h00, 0); chk_vals("R10");
    wr_reg(5'h10, 32'h0); chk_vals("R10");

    // R11 every-increment mode, reserved mode
    wr_reg(5'h08, 32'h0);
    wr_reg(5'h04, {26'd0, 4'd3, 2'b11});
    cyc(15'h0004, 1'b0, 5'h00, 0); chk_vals("R11");
    wr_reg(5'h04, {26'd0, 4'd3, 2'b10});
    chk_irq("R11");
    cyc(15'h0004, 1'b0, 5'h00, 0); chk_vals("R11");
    wr_reg(5'h0C, 32'h0); chk_vals("R11");

    // R7 extended codes: base instance must not count
    wr_reg(5'h04, {26'd0, 4'd10, 2'b00});
    wr_reg(5'h08, {26'd0, 4'd15, 2'b00});
    chk_reg(5'h04, "R7");
    cyc(15'h4200, 1'b0, 5'h00, 0); cyc(15'h0200, 1'b0, 5'h00, 0);
    chk_vals("R7");
    wr_reg(5'h04, {26'd0, 4'd9, 2'b00});
    cyc(15'h0100, 1'b0, 5'h00, 0);
    chk_vals("R7");

    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [14:0] e;
      logic        w;
      logic [4:0]  a;
      logic [31:0] d;
      e = 15'($urandom) & 15'($urandom);
      w = ($urandom % 6) == 0;
      case ($urandom % 5)
        0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08; 3: a = 5'h0C; default: a = 5'h10;
      endcase
      if (a == 5'h00)      d = {31'd0, 1'(($urandom % 8) != 0)};
      else if (a == 5'h04 || a == 5'h08) d = $urandom;
      else if ($urandom % 2) d = 32'hFFFF_FFF0 + 32'($urandom % 16);
      else d = 32'($urandom % 100);
      cyc(e, w, a, d);
      chk_vals("R6");
      if (n % 16 == 0) begin
        chk_reg(5'h04, "R2"); chk_reg(5'h08, "R2"); chk_reg(5'h00, "R2");
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule